// File: doc/BRIEF.md
# Shift-Add Multiplier Control Sequencer

This block is the hardwired control unit of a shift-add binary multiplier that spends two states per multiplier bit. It watches three status and control inputs: a start request, the zero flag of the datapath's down counter, and the least significant bit of the multiplier register. From these it drives four datapath strobes: register initialise, conditional add-and-load, carry clear, and shift-plus-counter-decrement. The datapath itself (operand registers, adder, counter) is not part of the block.

The sequencer has three states: waiting, add phase and shift phase. In the waiting state a start request launches a multiply. The add phase always moves on to the shift phase. The shift phase returns to the add phase until the counter zero flag is seen, and then goes back to waiting. Strobes that depend on the state alone are Moore outputs. Strobes that are also gated by the start request or the multiplier bit are Mealy outputs. Every datapath transfer happens at the clock edge that leaves the state.

A parameter picks one of two implementations. The default holds the state in a 2-bit encoded register and decodes it. The alternative uses one flip-flop per state, wired with demultiplexers, OR junctions and AND-gated outputs. Both must behave the same, cycle for cycle. Both also recover to the waiting state from any state pattern that is not legal.

Top module: `mul_seq_ctrl`

## Requirements
- R1: With the synchronous reset held at a clock edge, the sequencer is in the waiting state (code 00) in the next cycle. In that cycle all four strobes are 0 while start is 0.
- R2: In the waiting state, start=1 moves to the add phase (code 01) at the next edge, and start=0 keeps the waiting state.
- R3: The add phase always moves to the shift phase (code 10) at the next edge, whatever the inputs are.
- R4: In the shift phase, zero flag=1 moves to the waiting state and zero flag=0 moves to the add phase at the next edge.
- R5: The multiplier bit input never changes which state comes next.
- R6: The initialise strobe is 1 exactly when the state is waiting and start=1 (Mealy).
- R7: The add-and-load strobe is 1 exactly when the state is the add phase and the multiplier bit is 1 (Mealy).
- R8: The carry-clear strobe is 1 when the state is waiting and start=1, or when the state is the shift phase.
- R9: The shift-and-decrement strobe is 1 exactly when the state is the shift phase (Moore).
- R10: The one-flip-flop-per-state variant gives the same strobes as the encoded variant in every cycle, for any input sequence.
- R11: A reset asserted in the middle of a multiply returns the sequencer to the waiting state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request |
| cnt_zero_i | input | 1 | Down counter has reached zero |
| mplr_lsb_i | input | 1 | Least significant bit of the multiplier register |
| init_o | output | 1 | Initialise the accumulator and counter |
| add_load_o | output | 1 | Load the adder sum into the accumulator |
| clear_carry_o | output | 1 | Clear the carry flip-flop |
| shift_dec_o | output | 1 | Shift right and decrement the counter |

## Verification
The state is never visible directly. It can only be inferred from the strobes, and the add phase shows itself only while the multiplier bit is 1. The bench therefore runs a model of the sequencer beside both variants. It drives long pseudo-random streams of start, zero flag and multiplier bit, so that every state meets every input combination, including zero flags in the add phase and start requests during a multiply. Directed runs add back-to-back multiplies with no idle cycle between them, and a reset in the middle of a multiply.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

  localparam int CODE_W = 2;
  localparam int NUM_ST = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_WAIT  = 2'b00,
    ST_ADD   = 2'b01,
    ST_SHIFT = 2'b10,
    ST_BAD   = 2'b11
  } seq_code_t;

  typedef struct packed {
    logic wait_s;
    logic add_s;
    logic shift_s;
  } seq_dec_t;

  typedef struct packed {
    logic init;
    logic load;
    logic clr_c;
    logic shdec;
  } seq_ctl_t;

  function automatic logic f_start(input seq_dec_t s, input logic go);
    return s.wait_s & go;
  endfunction

  function automatic seq_ctl_t f_ctl(input seq_dec_t s, input logic go, input logic lsb);
    seq_ctl_t c;
    logic st;
    st      = f_start(s, go);
    c.init  = st;
    c.load  = s.add_s & lsb;
    c.clr_c = st | s.shift_s;
    c.shdec = s.shift_s;
    return c;
  endfunction

  function automatic seq_dec_t f_decode(input seq_code_t code);
    seq_dec_t d;
    d.wait_s  = (code == ST_WAIT);
    d.add_s   = (code == ST_ADD);
    d.shift_s = (code == ST_SHIFT);
    return d;
  endfunction

  function automatic logic f_legal_hot(input logic [NUM_ST-1:0] v);
    return $countones(v) == 1;
  endfunction

endpackage

// File: rtl/mul_seq_decoder.sv
module mul_seq_decoder
  import mul_seq_pkg::*;
(
  input  seq_code_t code_i,
  output seq_dec_t  dec_o
);
  always_comb dec_o = f_decode(code_i);
endmodule

// File: rtl/mul_seq_encoded.sv
module mul_seq_encoded
  import mul_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go_i,
  input  logic     cnt_zero_i,
  output seq_dec_t st_o
);
  seq_code_t code_q;
  seq_code_t code_d;
  seq_dec_t  dec;
  logic      start;

  mul_seq_decoder u_dec (
    .code_i (code_q),
    .dec_o  (dec)
  );

  always_comb begin
    start = f_start(dec, go_i);
    // M1 follows the add phase, M0 is start or a repeat from the shift phase
    code_d = seq_code_t'({dec.add_s, start | (dec.shift_s & ~cnt_zero_i)});
    if (code_q == ST_BAD) code_d = ST_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= ST_WAIT;
    else     code_q <= code_d;
  end

  assign st_o = dec;
endmodule

// File: rtl/mul_seq_onehot.sv
module mul_seq_onehot
  import mul_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go_i,
  input  logic     cnt_zero_i,
  output seq_dec_t st_o
);
  logic [NUM_ST-1:0] hot_q;
  logic [NUM_ST-1:0] hot_d;
  logic wait_x0, wait_x1;
  logic shf_x0, shf_x1;
  logic legal;

  // bit 2 = waiting, bit 1 = add phase, bit 0 = shift phase
  always_comb begin
    wait_x0 = hot_q[2] & ~go_i;
    wait_x1 = hot_q[2] &  go_i;
    shf_x0  = hot_q[0] & ~cnt_zero_i;
    shf_x1  = hot_q[0] &  cnt_zero_i;
    legal   = f_legal_hot(hot_q);
    if (legal) begin
      hot_d[2] = wait_x0 | shf_x1;
      hot_d[1] = wait_x1 | shf_x0;
      hot_d[0] = hot_q[1];
    end else begin
      hot_d = 3'b100;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 3'b100;
    else     hot_q <= hot_d;
  end

  assign st_o.wait_s  = hot_q[2];
  assign st_o.add_s   = hot_q[1];
  assign st_o.shift_s = hot_q[0];
endmodule

// File: rtl/mul_seq_outputs.sv
module mul_seq_outputs
  import mul_seq_pkg::*;
(
  input  seq_dec_t st_i,
  input  logic     go_i,
  input  logic     lsb_i,
  output seq_ctl_t ctl_o
);
  always_comb ctl_o = f_ctl(st_i, go_i, lsb_i);
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
  import mul_seq_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic cnt_zero_i,
  input  logic mplr_lsb_i,
  output logic init_o,
  output logic add_load_o,
  output logic clear_carry_o,
  output logic shift_dec_o
);
  seq_dec_t st;
  seq_ctl_t ctl;
  logic in_wait, in_add, in_shift;

  generate
    if (ONE_HOT) begin : g_hot
      mul_seq_onehot u_seq (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go_i),
        .cnt_zero_i (cnt_zero_i),
        .st_o       (st)
      );
    end else begin : g_enc
      mul_seq_encoded u_seq (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go_i),
        .cnt_zero_i (cnt_zero_i),
        .st_o       (st)
      );
    end
  endgenerate

  mul_seq_outputs u_out (
    .st_i  (st),
    .go_i  (go_i),
    .lsb_i (mplr_lsb_i),
    .ctl_o (ctl)
  );

  assign in_wait  = st.wait_s;
  assign in_add   = st.add_s;
  assign in_shift = st.shift_s;

  assign init_o        = ctl.init;
  assign add_load_o    = ctl.load;
  assign clear_carry_o = ctl.clr_c;
  assign shift_dec_o   = ctl.shdec;
endmodule

// File: rtl/mul_seq_ctrl_chk.sv
module mul_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic go_i,
  input logic cnt_zero_i,
  input logic mplr_lsb_i,
  input logic add_load_o,
  input logic shift_dec_o,
  input logic in_wait,
  input logic in_add,
  input logic in_shift
);
  assert_reset_wait_R1: assert property (@(posedge clk) rst |=> in_wait);
  assert_one_state_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({in_wait, in_add, in_shift}) == 1);
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (in_wait && go_i) |=> in_add);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !go_i) |=> in_wait);
  assert_add_to_shift_R3: assert property (@(posedge clk) disable iff (rst)
    in_add |=> in_shift);
  assert_done_R4: assert property (@(posedge clk) disable iff (rst)
    (in_shift && cnt_zero_i) |=> in_wait);
  assert_repeat_R4: assert property (@(posedge clk) disable iff (rst)
    (in_shift && !cnt_zero_i) |=> in_add);
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    add_load_o |-> (in_add && mplr_lsb_i));
  assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
    shift_dec_o == in_shift);
endmodule

bind mul_seq_ctrl mul_seq_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .go_i        (go_i),
  .cnt_zero_i  (cnt_zero_i),
  .mplr_lsb_i  (mplr_lsb_i),
  .add_load_o  (add_load_o),
  .shift_dec_o (shift_dec_o),
  .in_wait     (in_wait),
  .in_add      (in_add),
  .in_shift    (in_shift)
);

// File: tb/mul_seq_ctrl_test.sv
module mul_seq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, zf = 1'b0, lsb = 1'b0;
  logic e_init, e_load, e_clr, e_shd;
  logic h_init, h_load, h_clr, h_shd;
  int checks = 0;
  int fails = 0;
  int mst = 0; // 0 waiting, 1 add phase, 2 shift phase
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] fb;

  always #4 clk = ~clk;

  mul_seq_ctrl #(.ONE_HOT(1'b0)) uut (
    .clk(clk), .rst(rst), .go_i(go), .cnt_zero_i(zf), .mplr_lsb_i(lsb),
    .init_o(e_init), .add_load_o(e_load), .clear_carry_o(e_clr), .shift_dec_o(e_shd)
  );

  mul_seq_ctrl #(.ONE_HOT(1'b1)) uut_hot (
    .clk(clk), .rst(rst), .go_i(go), .cnt_zero_i(zf), .mplr_lsb_i(lsb),
    .init_o(h_init), .add_load_o(h_load), .clear_carry_o(h_clr), .shift_dec_o(h_shd)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b state=%0d", tag, act, exp, mst);
    end
  endtask

  // drive inputs, check both variants against the model, then advance one edge
  task automatic step(input logic r, input logic g, input logic z, input logic q, input string tag);
    logic xi, xl, xc, xs;
    @(negedge clk);
    rst = r; go = g; zf = z; lsb = q;
    #1;
    if (!r) begin
      xi = (mst == 0) && g;
      xl = (mst == 1) && q;
      xc = ((mst == 0) && g) || (mst == 2);
      xs = (mst == 2);
      chk({tag, " R6 init"}, e_init, xi);
      chk({tag, " R7 load"}, e_load, xl);
      chk({tag, " R8 clear"}, e_clr, xc);
      chk({tag, " R9 shift"}, e_shd, xs);
      chk({tag, " R10 hot init"}, h_init, xi);
      chk({tag, " R10 hot load"}, h_load, xl);
      chk({tag, " R10 hot clear"}, h_clr, xc);
      chk({tag, " R10 hot shift"}, h_shd, xs);
    end
    @(posedge clk);
    if (r) mst = 0;
    else case (mst)
      0: mst = g ? 1 : 0;
      1: mst = 2;
      default: mst = z ? 0 : 1;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, "reset");
    step(1, 1, 1, 1, "reset");
    // R1: waiting after reset, all strobes low with start low
    step(0, 0, 1, 1, "R1 reset idle");
    step(0, 0, 0, 1, "R2 hold");
    step(0, 1, 0, 0, "R2 start");
    step(0, 0, 1, 1, "R3 add phase zero flag high");
    step(0, 1, 0, 1, "R4 shift repeat");
    step(0, 1, 1, 0, "R5 add phase lsb low");
    step(0, 0, 1, 0, "R4 shift done");
    step(0, 1, 0, 1, "R4 back in waiting");
    // back-to-back multiplies with start held
    for (int k = 0; k < 12; k++) step(0, 1, k[1], k[0], "R5 back to back");
    // reset in mid multiply
    step(0, 1, 0, 1, "R11 pre");
    step(0, 0, 0, 1, "R11 pre");
    step(1, 0, 0, 1, "R11 reset");
    step(0, 0, 0, 1, "R11 after reset");
    step(0, 1, 0, 1, "R11 restart");
    step(0, 0, 0, 1, "R3 after restart");
    // pseudo-random sweep of every state against every input mix
    for (int n = 0; n < 6000; n++) begin
      fb = {15'd0, lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5]};
      lfsr = {fb[0], lfsr[15:1]};
      step((lfsr[9:4] == 6'd0), lfsr[1], lfsr[3] & lfsr[7], lfsr[5], "R5 sweep");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule